// File: doc/BRIEF.md
# Segment Display Memory Controller

This block holds the picture for a multiplexed segment display. Every frontplane/backplane crossing has two bits: one that says whether the segment is lit, and one that says whether the segment blinks. A host reads and writes both through a single register window. A bank-select pin decides which of the two banks that window reaches. A bulk-clear command zeroes the bank that is currently mapped, one word per clock, and reports busy until it is done. A blank pin darkens the whole display without changing memory. Per-frontplane enables and a module enable gate the result.

The outputs are the effective on/off states, one bit per segment, for a downstream waveform generator. Blink phase is an input, so the blink-rate divider lives elsewhere. Storage is 8-bit words. Bits 3:0 of word w belong to frontplane 2w and bits 7:4 to frontplane 2w+1, with the backplane index equal to the bit position within the nibble. Segment output bit `8*w + b` corresponds to bit b of word w. The host port has no back-pressure: a write is a one-cycle strobe and takes effect at the next edge unless a clear is running. The read port is combinational.

Top module: `segmem_ctrl`

## Requirements
- R1: After reset, every word of both banks reads 0, `clr_busy` is 0 and `seg_on` is all zeros.
- R2: With `bank_sel`=0, writes and reads reach the segment-data bank. With `bank_sel`=1, they reach the blink-enable bank. `rd_data` shows the addressed word of the selected bank in the same cycle, and a write is visible after the next clock edge.
- R3: When all gates are open and no blink is enabled, writing 1 to a data bit lights segment `8*w+b`, and writing 0 darkens it.
- R4: A `clr_start` pulse while idle zeroes every word of the bank selected at that edge. The other bank is left unchanged.
- R5: `clr_busy` rises after the edge that accepts `clr_start`, stays high for exactly NUM_WORDS cycles and then drops by itself. A `clr_start` seen while busy is ignored.
- R6: Host writes to either bank are ignored while `clr_busy` is 1.
- R7: The bank being cleared is the one latched at start. Changing `bank_sel` during the clear does not change which bank is zeroed.
- R8: While `blank` is 1, `seg_on` is all zeros regardless of memory and `bank_sel`. Memory contents are unchanged, and releasing `blank` restores the previous outputs.
- R9: Segment bit b of word w lights only if `mod_en` is 1 and `fp_en[2w + b/4]` is 1.
- R10: A segment whose blink-enable bit is 1 lights only while `blink_show` is 1. A segment whose blink-enable bit is 0 ignores `blink_show`.
- R11: In general, `seg_on[s]` = data[s] AND NOT blank AND mod_en AND fp_en[s/4] AND (NOT blink[s] OR blink_show).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_sel | input | 1 | 0 maps the data bank, 1 maps the blink bank |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | AW | Host write word address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | AW | Host read word address |
| rd_data | output | 8 | Addressed word of the mapped bank |
| clr_start | input | 1 | Start bulk clear of the mapped bank |
| clr_busy | output | 1 | Clear in progress |
| blank | input | 1 | Force all segments off |
| mod_en | input | 1 | Global module enable |
| fp_en | input | 2*NUM_WORDS | Per-frontplane enables |
| blink_show | input | 1 | Blink phase, 1 is the visible half |
| seg_on | output | 8*NUM_WORDS | Effective segment states |

## Verification
Directed patterns light single segments, then flip one gate at a time: a frontplane enable, the module enable, blank and blink phase. This separates a wrong frontplane mapping from a wrong gate. The clear is started on a bank filled with nonzero data, with writes and a bank flip issued mid-clear. That distinguishes a wrong bank, a wrong duration and leaking writes. Random phases mix writes to both banks with random gate settings and compare every output bit against a bench model of the full formula.

// File: rtl/segmem_pkg.sv
package segmem_pkg;
  localparam int unsigned WORD_W      = 8;
  localparam int unsigned BP_PER_FP   = 4;
  localparam int unsigned FP_PER_WORD = WORD_W / BP_PER_FP;

  typedef enum logic {
    BANK_DATA  = 1'b0,
    BANK_BLINK = 1'b1
  } bank_e;
endpackage

// File: rtl/segmem_bank.sv
module segmem_bank #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 3,
  localparam int unsigned W    = segmem_pkg::WORD_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_we,
  input  logic [AW-1:0]        host_addr,
  input  logic [W-1:0]         host_wdata,
  input  logic                 clr_we,
  input  logic [AW-1:0]        clr_addr,
  input  logic [AW-1:0]        rd_addr,
  output logic [W-1:0]         rd_data,
  output logic [DEPTH*W-1:0]   flat
);
  logic [W-1:0] mem [DEPTH];

  logic host_in_range, rd_in_range;
  assign host_in_range = {1'b0, host_addr} < (AW+1)'(DEPTH);
  assign rd_in_range   = {1'b0, rd_addr}   < (AW+1)'(DEPTH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
    end else if (clr_we) begin
      mem[clr_addr] <= '0;
    end else if (host_we && host_in_range) begin
      mem[host_addr] <= host_wdata;
    end
  end

  assign rd_data = rd_in_range ? mem[rd_addr] : '0;

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_flat
    assign flat[g*W +: W] = mem[g];
  end

  // R4: a clear strobe zeroes its word
  a_r4_word_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> mem[$past(clr_addr)] == '0);

  // R2: an accepted host write lands
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    host_we && !clr_we && host_in_range |=> mem[$past(host_addr)] == $past(host_wdata));
endmodule

// File: rtl/segmem_clr_seq.sv
module segmem_clr_seq #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          bank_sel,
  output logic          busy,
  output logic [AW-1:0] clr_addr,
  output logic          clr_we_data,
  output logic          clr_we_blink
);
  import segmem_pkg::*;

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr;
  bank_e         bank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      ptr    <= '0;
      bank_q <= BANK_DATA;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        ptr    <= '0;
        bank_q <= bank_e'(bank_sel);
      end
    end else if (ptr == LAST) begin
      busy <= 1'b0;
    end else begin
      ptr <= ptr + 1'b1;
    end
  end

  assign clr_addr     = ptr;
  assign clr_we_data  = busy && (bank_q == BANK_DATA);
  assign clr_we_blink = busy && (bank_q == BANK_BLINK);

  a_r5_starts: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy && ptr == '0);
  a_r5_holds: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ptr != LAST |=> busy && ptr == $past(ptr) + 1'b1);
  a_r5_ends: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ptr == LAST |=> !busy);
  a_r7_bank_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(bank_q));
  a_r7_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_we_data && clr_we_blink));
endmodule

// File: rtl/segmem_gate.sv
module segmem_gate #(
  parameter int unsigned NSEG = 64,
  parameter int unsigned NFP  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSEG-1:0] data,
  input  logic [NSEG-1:0] blink,
  input  logic            blank,
  input  logic            mod_en,
  input  logic [NFP-1:0]  fp_en,
  input  logic            blink_show,
  output logic [NSEG-1:0] seg_on
);
  import segmem_pkg::*;

  logic global_open;
  assign global_open = mod_en && !blank;

  for (genvar s = 0; s < int'(NSEG); s++) begin : g_seg
    localparam int unsigned FP = s / BP_PER_FP;
    logic visible;
    assign visible   = !blink[s] || blink_show;
    assign seg_on[s] = data[s] && global_open && fp_en[FP] && visible;

    a_r9_fp_gate: assert property (@(posedge clk) disable iff (!rst_n)
      seg_on[s] |-> fp_en[FP] && data[s]);
  end

  a_r8_blank_dark: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> seg_on == '0);
  a_r9_module_off: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |-> seg_on == '0);
  a_r10_blink_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    !blink_show |-> (seg_on & blink) == '0);
endmodule

// File: rtl/segmem_ctrl.sv
module segmem_ctrl #(
  parameter int unsigned NUM_WORDS = 8,
  localparam int unsigned AW   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int unsigned W    = segmem_pkg::WORD_W,
  localparam int unsigned NSEG = NUM_WORDS * W,
  localparam int unsigned NFP  = NUM_WORDS * segmem_pkg::FP_PER_WORD
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bank_sel,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [W-1:0]    wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [W-1:0]    rd_data,
  input  logic            clr_start,
  output logic            clr_busy,
  input  logic            blank,
  input  logic            mod_en,
  input  logic [NFP-1:0]  fp_en,
  input  logic            blink_show,
  output logic [NSEG-1:0] seg_on
);
  import segmem_pkg::*;

  logic [AW-1:0]   clr_addr;
  logic            clr_we_data, clr_we_blink;
  logic            host_we_data, host_we_blink;
  logic [W-1:0]    rd_data_bank, rd_blink_bank;
  logic [NSEG-1:0] data_flat, blink_flat;

  segmem_clr_seq #(.DEPTH(NUM_WORDS), .AW(AW)) i_clr (
    .clk, .rst_n,
    .start       (clr_start),
    .bank_sel    (bank_sel),
    .busy        (clr_busy),
    .clr_addr    (clr_addr),
    .clr_we_data (clr_we_data),
    .clr_we_blink(clr_we_blink)
  );

  assign host_we_data  = wr_en && !clr_busy && (bank_e'(bank_sel) == BANK_DATA);
  assign host_we_blink = wr_en && !clr_busy && (bank_e'(bank_sel) == BANK_BLINK);

  segmem_bank #(.DEPTH(NUM_WORDS), .AW(AW)) i_data_bank (
    .clk, .rst_n,
    .host_we   (host_we_data),
    .host_addr (wr_addr),
    .host_wdata(wr_data),
    .clr_we    (clr_we_data),
    .clr_addr  (clr_addr),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data_bank),
    .flat      (data_flat)
  );

  segmem_bank #(.DEPTH(NUM_WORDS), .AW(AW)) i_blink_bank (
    .clk, .rst_n,
    .host_we   (host_we_blink),
    .host_addr (wr_addr),
    .host_wdata(wr_data),
    .clr_we    (clr_we_blink),
    .clr_addr  (clr_addr),
    .rd_addr   (rd_addr),
    .rd_data   (rd_blink_bank),
    .flat      (blink_flat)
  );

  assign rd_data = bank_sel ? rd_blink_bank : rd_data_bank;

  segmem_gate #(.NSEG(NSEG), .NFP(NFP)) i_gate (
    .clk, .rst_n,
    .data      (data_flat),
    .blink     (blink_flat),
    .blank     (blank),
    .mod_en    (mod_en),
    .fp_en     (fp_en),
    .blink_show(blink_show),
    .seg_on    (seg_on)
  );

  // R6: memory words do not move from host traffic during a clear
  a_r6_no_host_write: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy && wr_en && !bank_sel && !clr_we_data |=> $stable(data_flat));
endmodule

// File: tb/test_segmem_ctrl.sv
module test_segmem_ctrl;
  localparam int NW = 8, AW = 3, NSEG = 64, NFP = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, bank_sel, wr_en, clr_start, clr_busy, blank, mod_en, blink_show;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic [NFP-1:0] fp_en;
  logic [NSEG-1:0] seg_on;

  segmem_ctrl #(.NUM_WORDS(NW)) i_segmem_ctrl (
    .clk, .rst_n, .bank_sel, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .clr_start, .clr_busy, .blank, .mod_en, .fp_en, .blink_show, .seg_on
  );

  logic [7:0] m_seg [NW];
  logic [7:0] m_blk [NW];
  int n_chk = 0, n_fail = 0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [NSEG-1:0] exp_out();
    logic [NSEG-1:0] r;
    for (int s = 0; s < NSEG; s++) begin
      r[s] = m_seg[s/8][s%8] && !blank && mod_en && fp_en[s/4] &&
             (!m_blk[s/8][s%8] || blink_show);
    end
    return r;
  endfunction

  task automatic wr(bit b, int a, logic [7:0] d);
    @(negedge clk);
    bank_sel = b; wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (b) m_blk[a] = d; else m_seg[a] = d;
  endtask

  task automatic rd_check(string req, bit b, int a);
    bank_sel = b; rd_addr = AW'(a);
    #1;
    check(req, rd_data, b ? m_blk[a] : m_seg[a]);
  endtask

  task automatic all_reads(string req);
    for (int a = 0; a < NW; a++) begin
      @(negedge clk);
      rd_check(req, 1'b0, a);
      rd_check(req, 1'b1, a);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    int cnt;
    void'($urandom(32'd4711));
    rst_n = 0; bank_sel = 0; wr_en = 0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    clr_start = 0; blank = 0; mod_en = 1; fp_en = '1; blink_show = 1;
    for (int a = 0; a < NW; a++) begin m_seg[a] = '0; m_blk[a] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", clr_busy, 0);
    check("R1 seg_on", seg_on, 0);
    all_reads("R1 read");

    // R3 / R2 directed
    wr(0, 2, 8'h81);
    check("R3 lit", seg_on, 64'h1 << 16 | 64'h1 << 23);
    rd_check("R2 data read", 0, 2);
    rd_check("R2 blink untouched", 1, 2);
    wr(0, 2, 8'h00);
    check("R3 dark", seg_on, 0);

    // R9 frontplane mapping
    wr(0, 2, 8'hFF);
    fp_en = 16'h0020; #1;
    check("R9 fp5", seg_on, 64'hF0 << 16);
    fp_en = 16'h0010; #1;
    check("R9 fp4", seg_on, 64'h0F << 16);
    fp_en = '1; mod_en = 0; #1;
    check("R9 mod_en", seg_on, 0);
    mod_en = 1;

    // R10 blink
    wr(1, 2, 8'h0F);
    rd_check("R2 blink read", 1, 2);
    blink_show = 0; #1;
    check("R10 hidden", seg_on, 64'hF0 << 16);
    blink_show = 1; #1;
    check("R10 shown", seg_on, 64'hFF << 16);

    // R8 blank
    blank = 1; bank_sel = 1; #1;
    check("R8 blank", seg_on, 0);
    bank_sel = 0; #1;
    check("R8 blank bank0", seg_on, 0);
    rd_check("R8 mem kept", 0, 2);
    rd_check("R8 blink kept", 1, 2);
    blank = 0; #1;
    check("R8 release", seg_on, exp_out());

    // Fill both banks, then clear data bank with interference
    for (int a = 0; a < NW; a++) begin
      wr(0, a, 8'(($urandom % 255) + 1));
      wr(1, a, 8'(($urandom % 255) + 1));
    end
    @(negedge clk);
    bank_sel = 0; clr_start = 1;
    @(negedge clk);
    check("R5 busy rise", clr_busy, 1);
    clr_start = 1; cnt = 0;
    while (clr_busy && cnt < 100) begin
      cnt++;
      if (cnt == 2) begin bank_sel = 0; wr_en = 1; wr_addr = 3'd0; wr_data = 8'hA5; end
      else if (cnt == 3) begin bank_sel = 1; wr_en = 1; wr_addr = 3'd1; wr_data = 8'h5A; end
      else wr_en = 0;
      if (cnt == 4) bank_sel = 1;
      if (cnt > 1) clr_start = 0;
      @(negedge clk);
    end
    wr_en = 0; clr_start = 0;
    check("R5 busy length", cnt, NW);
    for (int a = 0; a < NW; a++) m_seg[a] = '0;
    all_reads("R4 R6 R7 after clear");
    check("R5 idle", clr_busy, 0);

    // R4 clear blink bank
    @(negedge clk);
    bank_sel = 1; clr_start = 1;
    @(negedge clk);
    clr_start = 0; bank_sel = 0;
    repeat (NW) @(negedge clk);
    check("R5 done blink", clr_busy, 0);
    for (int a = 0; a < NW; a++) m_blk[a] = '0;
    all_reads("R4 blink clear");

    // R11 random
    for (int it = 0; it < 300; it++) begin
      wr($urandom % 2, $urandom % NW, 8'($urandom));
      blank = ($urandom % 5) == 0;
      mod_en = ($urandom % 6) != 0;
      fp_en = NFP'($urandom) | NFP'($urandom);
      blink_show = $urandom % 2;
      #1;
      check("R11 random", seg_on, exp_out());
    end
    all_reads("R2 random read");

    summary();
    $finish;
  end
endmodule